// File: doc/BRIEF.md
# Interrupt Edge/Level Trigger Control

This block decides, for each of sixteen interrupt request lines, how a request is recognized. The lines are split into a low bank (channels 0 to 7) and a high bank (channels 8 to 15), and each bank has an 8-bit mode byte. A mode bit of 0 selects edge recognition, where a request is seen once when the line goes from low to high. A mode bit of 1 selects level recognition, where the request is seen for as long as the line stays high.

The two mode bytes sit at two consecutive byte addresses on a simple I/O-style port. Writes take effect on the clock edge. Reads return the data combinationally. Five system channels are locked to edge recognition: 0, 1, 2, 8 and 13. Their mode bits ignore writes and always read back as 0. Every raw line is registered once. The block then produces a 16-bit vector of recognized requests, which a downstream priority stage consumes.

Top module: `irq_trigger_ctl`

## Requirements
- R1: After reset both mode bytes read 00h, so all channels use edge recognition.
- R2: The low-bank byte is at address BASE (default 16'h04D0). Bit n of that byte holds the mode of channel n, and bits 7:3 are writable.
- R3: The high-bank byte is at address BASE+1. Bit n of that byte holds the mode of channel 8+n, and bits 7:6 and 4:1 are writable.
- R4: Writes to low-byte bits 2:0 and to high-byte bits 5 and 0 are ignored, and those bits always read 0.
- R5: In edge mode, a channel's output goes high for exactly one clock after the clock edge at which its input is sampled high, provided the previous sample was low.
- R6: In level mode, a channel's output is high after every clock edge at which its input is sampled high, and low otherwise.
- R7: Channels 0, 1, 2, 8 and 13 always use edge recognition, whatever value was written to the mode bytes.
- R8: A write to any address other than BASE and BASE+1 changes neither mode byte, and a read from such an address returns 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the register port |
| addr | input | 16 | Byte address on the register port |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from addr |
| irq_in | input | 16 | Raw request lines |
| irq_rec | output | 16 | Recognized requests |

## Verification
The hardest situation to reach is a change of mode in the middle of activity, while lines are already held high. The prior sample and the current mode then decide together whether a channel stays asserted. To reach it, the bench mixes register writes into a long stream of pseudo-random input patterns, so that channels switch mode while their inputs are high. A bench-side model, driven only by the applied inputs and written bytes, computes each expected output. Every value of both bytes is also written and read back.

// File: rtl/irq_trigger_ctl.sv
module irq_trigger_ctl #(
  parameter int          ADDR_W    = 16,
  parameter logic [15:0] BASE      = 16'h04D0,
  parameter logic [15:0] LOCK_MASK = 16'h2107
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic [15:0]       irq_in,
  output logic [15:0]       irq_rec
);
  localparam logic [ADDR_W-1:0] LO_ADDR = ADDR_W'(BASE);
  localparam logic [ADDR_W-1:0] HI_ADDR = ADDR_W'(BASE + 16'd1);
  localparam logic [15:0]       WMASK   = ~LOCK_MASK;

  logic [15:0] mode;
  logic [15:0] samp;
  logic [15:0] prev;

  wire hit_lo = (addr == LO_ADDR);
  wire hit_hi = (addr == HI_ADDR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode <= '0;
      samp <= '0;
      prev <= '0;
    end else begin
      if (wr_en && hit_lo) mode[7:0]  <= wdata & WMASK[7:0];
      if (wr_en && hit_hi) mode[15:8] <= wdata & WMASK[15:8];
      samp <= irq_in;
      prev <= samp;
    end
  end

  assign rdata   = hit_lo ? mode[7:0] : hit_hi ? mode[15:8] : 8'h00;
  assign irq_rec = samp & (mode | ~prev);

  // R5
  edge_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((irq_rec & $past(irq_rec) & ~mode & ~$past(mode)) == 16'h0));

  // R6
  rec_needs_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((irq_rec & ~$past(irq_in)) == 16'h0));

  // R7
  locked_edge_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_rec & prev & LOCK_MASK) == 16'h0));

  // R8
  stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !hit_lo && !hit_hi) |=> $stable(mode));

  // R4
  reserved_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_lo |-> (rdata[2:0] == 3'b000));
endmodule

// File: tb/irq_trigger_ctl_tb.sv
module irq_trigger_ctl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] addr = 16'h0;
  logic [7:0]  wdata = 8'h0;
  logic [15:0] irq_in = 16'h0;
  logic [7:0]  rdata;
  logic [15:0] irq_rec;

  int checks = 0;
  int errors = 0;
  logic [15:0] m_mode = 16'h0, m_cur = 16'h0, m_prev = 16'h0, exp_rec;
  logic [15:0] lfsr = 16'hACE1;

  always #10 clk = ~clk;

  irq_trigger_ctl u_dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq_in(irq_in), .irq_rec(irq_rec));

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic [15:0] inp, input bit w, input logic [15:0] a, input logic [7:0] d, input string req);
    @(negedge clk);
    irq_in = inp; wr_en = w; addr = a; wdata = d;
    @(posedge clk);
    if (w && a == 16'h04D0) m_mode[7:0]  = d & 8'hF8;
    if (w && a == 16'h04D1) m_mode[15:8] = d & 8'hDE;
    m_prev = m_cur;
    m_cur  = inp;
    exp_rec = m_cur & (m_mode | ~m_prev);
    #1;
    chk(irq_rec === exp_rec, req, irq_rec, exp_rec);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, input logic [7:0] exp, input string req);
    @(negedge clk);
    addr = a;
    #1;
    chk(rdata === exp, req, {8'h0, rdata}, {8'h0, exp});
  endtask

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1 reset state
    rd(16'h04D0, 8'h00, "R1 low byte");
    rd(16'h04D1, 8'h00, "R1 high byte");
    chk(irq_rec === 16'h0, "R1 rec", irq_rec, 16'h0);

    // R2 R3 R4 exhaustive write/read-back
    for (int v = 0; v < 256; v++) begin
      step(16'h0, 1'b1, 16'h04D0, 8'(v), "R2 rec");
      rd(16'h04D0, 8'(v) & 8'hF8, "R2 R4 low readback");
      step(16'h0, 1'b1, 16'h04D1, 8'(v), "R3 rec");
      rd(16'h04D1, 8'(v) & 8'hDE, "R3 R4 high readback");
    end

    // R8 stray writes and reads
    step(16'h0, 1'b1, 16'h04D0, 8'h58, "R8 rec");
    step(16'h0, 1'b1, 16'h04D1, 8'h92, "R8 rec");
    for (int k = 0; k < 8; k++) begin
      logic [15:0] sa;
      sa = (k < 4) ? 16'h04CC + 16'(k) : 16'h04D2 + 16'(k);
      step(16'h0, 1'b1, sa, 8'hFF, "R8 rec");
      rd(sa, 8'h00, "R8 stray read");
    end
    rd(16'h04D0, 8'h58, "R8 low unchanged");
    rd(16'h04D1, 8'h92, "R8 high unchanged");

    // R5 R6 R7: all edge, then all level
    step(16'h0, 1'b1, 16'h04D0, 8'h00, "R5 setup");
    step(16'h0, 1'b1, 16'h04D1, 8'h00, "R5 setup");
    step(16'hFFFF, 1'b0, 16'h0, 8'h0, "R5 rising");
    chk(irq_rec === 16'hFFFF, "R5 pulse", irq_rec, 16'hFFFF);
    step(16'hFFFF, 1'b0, 16'h0, 8'h0, "R5 held");
    chk(irq_rec === 16'h0, "R5 single cycle", irq_rec, 16'h0);
    step(16'h0, 1'b1, 16'h04D0, 8'hFF, "R6 setup");
    step(16'h0, 1'b1, 16'h04D1, 8'hFF, "R6 setup");
    step(16'hFFFF, 1'b0, 16'h0, 8'h0, "R6 rising");
    step(16'hFFFF, 1'b0, 16'h0, 8'h0, "R6 held");
    chk(irq_rec === 16'hDEF8, "R6 R7 held level", irq_rec, 16'hDEF8);
    step(16'h0, 1'b0, 16'h0, 8'h0, "R6 drop");
    chk(irq_rec === 16'h0, "R6 low", irq_rec, 16'h0);

    // R5 R6 R7 random stream with mode changes
    for (int n = 0; n < 3000; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (n % 37 == 5)
        step(lfsr, 1'b1, 16'h04D0, lfsr[11:4], "R5 R6 R7 stream");
      else if (n % 41 == 9)
        step(lfsr, 1'b1, 16'h04D1, lfsr[15:8], "R5 R6 R7 stream");
      else
        step((n % 3 == 0) ? lfsr : m_cur | lfsr, 1'b0, 16'h0, 8'h0, "R5 R6 R7 stream");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule